// File: doc/BRIEF.md
# DMA Sound Instruction Sequencer

One channel of a sound DMA engine. The channel reads 16-bit instruction words from memory, one at a time, starting at an address the CPU supplies. It runs each word as it arrives. A word can write a byte to a sound-generator register, wait for a number of display line ticks, open a counted loop, or carry control flags for loop-back, interrupt and stop. The sound generator and the arbitration between channels sit outside this block.

The CPU loads a start address while the channel is idle and then sets the channel's enable bit. The channel clears that bit itself when it runs a stop word. Its instruction address is then left on the word after the stop, so setting the enable bit again carries on from that point. Only one loop can be open at a time. A repeat word with count N runs the body up to the loop flag N+1 times. A repeat or pause with a count of zero does nothing.

Top module: `snd_dma_channel`

## Requirements
- R1: After reset the enable bit is 0 and `mem_req`, `reg_wr` and `irq` are all low.
- R2: A CPU set pulse sets the enable bit on the next clock. A CPU clear in the same cycle wins over the set. `addr_wr` loads the instruction address only while the channel is disabled and is ignored while it is enabled.
- R3: While fetching, `mem_req` stays high with `mem_addr` equal to the instruction address until `mem_valid` is seen. Each accepted word advances the address by one.
- R4: A word with top nibble 0h writes a register. `reg_wr` is high for one cycle, `reg_sel` carries bits 11..8 of the word and `reg_data` carries bits 7..0.
- R5: A word with top nibble 1h and a 12-bit count N (N>0) delays the next fetch until N `line_tick` pulses have been seen. With N=0 the next fetch follows at once.
- R6: A word with top nibble 2h and a 12-bit count N (N>0) stores the address of the next word and the count N. The body up to a loop flag then runs N+1 times in all. With N=0 the body runs once.
- R7: A word with top nibble 4h is a control word with flags that can be combined: bit 0 loops back, bit 4 raises the interrupt, bit 5 stops. A loop flag jumps back to the stored address while the stored count is non-zero and then lowers the count by one. Otherwise execution falls through.
- R8: The interrupt flag gives a one-cycle pulse on `irq`. Execution goes on unless the stop flag is also set.
- R9: The stop flag clears the enable bit and leaves the instruction address on the following word. A later set resumes fetching from that word.
- R10: Once a CPU clear has taken effect, no further memory requests are made, and a pending pause is dropped. A re-enable then fetches at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_en_set | input | 1 | CPU pulse that sets the enable bit |
| cpu_en_clr | input | 1 | CPU pulse that clears the enable bit |
| addr_wr | input | 1 | CPU strobe that loads the start address |
| addr_in | input | AW | Start address, in words |
| line_tick | input | 1 | One pulse per display line, paces pauses |
| mem_addr | output | AW | Word address of the fetch |
| mem_req | output | 1 | Fetch request, held until valid |
| mem_data | input | 16 | Returned instruction word |
| mem_valid | input | 1 | `mem_data` holds the requested word |
| reg_wr | output | 1 | Sound register write strobe |
| reg_sel | output | 4 | Sound register number |
| reg_data | output | 8 | Sound register value |
| irq | output | 1 | One-cycle interrupt request pulse |
| chan_en | output | 1 | Channel enable status bit |

## Verification
The enable bit shows one clock after a set pulse, and the first `mem_req` comes one clock after that. The bench memory returns the word one clock after the request. The write strobe and interrupt pulse of that word then appear in the execute cycle, two clocks after the request rose. After the last line tick of a pause, the next request follows within two clocks. The bench samples outputs on the falling edge. It steps exact clock counts where it checks the resume address and the held request. Line ticks are spaced ten clocks apart, so each tick falls in the pause wait state, and a write that is early or late shows up as a wrong write count.

// File: rtl/sdma_pkg.sv
// Shared encodings for the sound DMA sequencer.
// Assumes 16-bit instruction words with the opcode in the top nibble.
package sdma_pkg;
    localparam int IW   = 16;
    localparam int ARGW = 12;
    localparam int SELW = 4;
    localparam int DATW = 8;

    localparam logic [3:0] OP_LOAD   = 4'h0;
    localparam logic [3:0] OP_PAUSE  = 4'h1;
    localparam logic [3:0] OP_REPEAT = 4'h2;
    localparam logic [3:0] OP_CTRL   = 4'h4;

    localparam int FLAG_LOOP = 0;
    localparam int FLAG_INT  = 4;
    localparam int FLAG_STOP = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/sdma_enable.sv
// Channel enable bit: the CPU sets it; a CPU clear or a stop word clears it.
// Assumes that a clear wins over a set arriving in the same cycle.
module sdma_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_set,
    input  logic cpu_clr,
    input  logic stop_clr,
    output logic en
);
    // Hold the enable bit, with clear taking priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)                  en <= 1'b0;
        else if (cpu_clr || stop_clr) en <= 1'b0;
        else if (cpu_set)            en <= 1'b1;
    end

    // R2
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clr |=> !en);
    // R9
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_clr |=> !en);
endmodule

// File: rtl/sdma_loop_unit.sv
// Single loop store: holds the return address and the remaining count.
// Assumes no nesting; a new repeat simply replaces the stored state.
module sdma_loop_unit #(
    parameter int AW   = 16,
    parameter int ARGW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rep_load,
    input  logic [ARGW-1:0] rep_count,
    input  logic [AW-1:0]   rep_addr,
    input  logic            loop_req,
    output logic            loop_taken,
    output logic [AW-1:0]   loop_addr
);
    logic [ARGW-1:0] cnt;

    assign loop_taken = loop_req && (cnt != '0);

    // Store on repeat, count down on each taken loop-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            loop_addr <= '0;
        end else if (rep_load) begin
            cnt       <= rep_count;
            loop_addr <= rep_addr;
        end else if (loop_taken) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R6
    count_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rep_load |=> cnt <= $past(cnt));
endmodule

// File: rtl/sdma_pause_timer.sv
// Line-tick down-counter for pause words.
// Assumes start and abort never coincide with a wanted tick; start wins.
module sdma_pause_timer #(
    parameter int ARGW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [ARGW-1:0] count,
    input  logic            tick,
    input  logic            abort,
    output logic            busy
);
    logic [ARGW-1:0] cnt;

    assign busy = (cnt != '0);

    // Load, drop or count down the remaining line ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (start)          cnt <= count;
        else if (abort)          cnt <= '0;
        else if (tick && busy)   cnt <= cnt - 1'b1;
    end

    // R5
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !tick && !start && !abort |=> cnt == $past(cnt));
endmodule

// File: rtl/snd_dma_channel.sv
// One sound DMA channel: fetches 16-bit words and runs them in order.
// Assumes memory holds mem_data steady in the cycle mem_valid is high
// and answers only while mem_req is high.
module snd_dma_channel
    import sdma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_en_set,
    input  logic            cpu_en_clr,
    input  logic            addr_wr,
    input  logic [AW-1:0]   addr_in,
    input  logic            line_tick,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_req,
    input  logic [IW-1:0]   mem_data,
    input  logic            mem_valid,
    output logic            reg_wr,
    output logic [SELW-1:0] reg_sel,
    output logic [DATW-1:0] reg_data,
    output logic            irq,
    output logic            chan_en
);
    seq_state_e      state, state_nx;
    logic [AW-1:0]   pc;
    logic [IW-1:0]   instr;
    logic [3:0]      op;
    logic [ARGW-1:0] arg;
    logic            en, exec, accept;
    logic            is_load, is_pause, is_rep, is_ctrl;
    logic            f_loop, f_int, f_stop;
    logic            loop_taken, pause_busy;
    logic [AW-1:0]   loop_addr;

    assign op       = instr[IW-1:IW-4];
    assign arg      = instr[ARGW-1:0];
    assign exec     = (state == ST_EXEC) && en;
    assign accept   = (state == ST_FETCH) && en && mem_valid;
    assign is_load  = exec && (op == OP_LOAD);
    assign is_pause = exec && (op == OP_PAUSE) && (arg != '0);
    assign is_rep   = exec && (op == OP_REPEAT) && (arg != '0);
    assign is_ctrl  = exec && (op == OP_CTRL);
    assign f_loop   = is_ctrl && instr[FLAG_LOOP];
    assign f_int    = is_ctrl && instr[FLAG_INT];
    assign f_stop   = is_ctrl && instr[FLAG_STOP];

    sdma_enable u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_set  (cpu_en_set),
        .cpu_clr  (cpu_en_clr),
        .stop_clr (f_stop),
        .en       (en)
    );

    sdma_loop_unit #(.AW(AW), .ARGW(ARGW)) u_loop (
        .clk        (clk),
        .rst_n      (rst_n),
        .rep_load   (is_rep),
        .rep_count  (arg),
        .rep_addr   (pc),
        .loop_req   (f_loop),
        .loop_taken (loop_taken),
        .loop_addr  (loop_addr)
    );

    sdma_pause_timer #(.ARGW(ARGW)) u_pause (
        .clk   (clk),
        .rst_n (rst_n),
        .start (is_pause),
        .count (arg),
        .tick  (line_tick),
        .abort (!en),
        .busy  (pause_busy)
    );

    // Next-state choice of the fetch / execute / wait sequence.
    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_FETCH;
                ST_FETCH: if (mem_valid) state_nx = ST_EXEC;
                ST_EXEC: begin
                    if (f_stop)        state_nx = ST_IDLE;
                    else if (is_pause) state_nx = ST_WAIT;
                    else               state_nx = ST_FETCH;
                end
                ST_WAIT:  if (!pause_busy) state_nx = ST_FETCH;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // State, instruction address and instruction word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pc    <= '0;
            instr <= '0;
        end else begin
            state <= state_nx;
            if (addr_wr && !en)  pc <= addr_in;
            else if (accept)     pc <= pc + AW'(1);
            else if (loop_taken) pc <= loop_addr;
            if (accept) instr <= mem_data;
        end
    end

    assign mem_req  = (state == ST_FETCH);
    assign mem_addr = pc;
    assign reg_wr   = is_load;
    assign reg_sel  = instr[ARGW-1:DATW];
    assign reg_data = instr[DATW-1:0];
    assign irq      = f_int;
    assign chan_en  = en;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid && chan_en && !cpu_en_clr
        |=> mem_req && mem_addr == $past(mem_addr));
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R10
    no_req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en && !$past(chan_en) |-> !mem_req);
    // R2
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en && !addr_wr |=> mem_addr == $past(mem_addr));
endmodule

// File: tb/test_snd_dma_channel.sv
`timescale 1ns/1ps
module test_snd_dma_channel;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_en_set = 1'b0, cpu_en_clr = 1'b0, addr_wr = 1'b0, line_tick = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] mem_addr;
    logic mem_req, mem_valid = 1'b0, reg_wr, irq, chan_en;
    logic [15:0] mem_data = '0;
    logic [3:0] reg_sel;
    logic [7:0] reg_data;

    logic [15:0] mem [0:63];
    int tests = 0, fails = 0;
    int wr_cnt = 0, irq_cnt = 0, sel1_cnt = 0, sel3_cnt = 0;
    logic [3:0] last_sel = '0;
    logic [7:0] last_data = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    snd_dma_channel #(.AW(AW)) i_snd_dma_channel (
        .clk(clk), .rst_n(rst_n), .cpu_en_set(cpu_en_set), .cpu_en_clr(cpu_en_clr),
        .addr_wr(addr_wr), .addr_in(addr_in), .line_tick(line_tick),
        .mem_addr(mem_addr), .mem_req(mem_req), .mem_data(mem_data),
        .mem_valid(mem_valid), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_data(reg_data), .irq(irq), .chan_en(chan_en)
    );

    // Behavioural memory: answers one clock after a request.
    always @(posedge clk) begin
        if (!rst_n) mem_valid <= 1'b0;
        else        mem_valid <= mem_req && !mem_valid;
        mem_data <= mem[mem_addr[5:0]];
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && reg_wr) begin
            wr_cnt++;
            last_sel  = reg_sel;
            last_data = reg_data;
            if (reg_sel == 4'd1) sel1_cnt++;
            if (reg_sel == 4'd3) sel3_cnt++;
        end
        if (rst_n && irq) irq_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        wr_cnt = 0; irq_cnt = 0; sel1_cnt = 0; sel3_cnt = 0;
    endtask

    task automatic fill_stop();
        for (int i = 0; i < 64; i++) mem[i] = 16'h4020;
    endtask

    task automatic start_at(input logic [AW-1:0] a);
        addr_wr = 1'b1; addr_in = a; cyc(1);
        addr_wr = 1'b0; cpu_en_set = 1'b1; cyc(1);
        cpu_en_set = 1'b0;
    endtask

    task automatic wait_off(input int maxc);
        for (int i = 0; i < maxc && chan_en; i++) cyc(1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        fill_stop();
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check(chan_en == 0, "R1", chan_en, 0);
        check(mem_req == 0, "R1", mem_req, 0);
        check(irq == 0, "R1", irq, 0);
        check(reg_wr == 0, "R1", reg_wr, 0);

        // R6/R4/R7: repeat sweep, body must run N+1 times
        for (int n = 0; n < 6; n++) begin
            fill_stop();
            mem[0] = 16'h2000 | 16'(n);
            mem[1] = 16'h0100 | 16'(n);
            mem[2] = 16'h4001;
            mem[3] = 16'h02AA;
            mem[4] = 16'h4030;
            clear_counts();
            start_at(0);
            wait_off(500);
            cyc(2);
            check(sel1_cnt == n + 1, "R6", sel1_cnt, n + 1);
            check(last_sel == 4'd2 && last_data == 8'hAA, "R4", last_data, 8'hAA);
            check(irq_cnt == 1, "R7", irq_cnt, 1);
            check(chan_en == 0, "R9", chan_en, 0);
        end

        // R7/R8: loop flag ORed with interrupt, execution carries on
        fill_stop();
        mem[8]  = 16'h2002;
        mem[9]  = 16'h0305;
        mem[10] = 16'h4011;
        mem[11] = 16'h4020;
        clear_counts();
        start_at(8);
        wait_off(500);
        cyc(2);
        check(sel3_cnt == 3, "R7", sel3_cnt, 3);
        check(irq_cnt == 3, "R8", irq_cnt, 3);
        check(chan_en == 0, "R9", chan_en, 0);

        // R5: pause sweep, next word only after N line ticks
        for (int n = 0; n < 5; n++) begin
            bit early;
            fill_stop();
            mem[16] = 16'h0101;
            mem[17] = 16'h1000 | 16'(n);
            mem[18] = 16'h0202;
            clear_counts();
            early = 0;
            start_at(16);
            for (int i = 0; i < 50 && wr_cnt < 1; i++) cyc(1);
            cyc(10);
            for (int t = 0; t < n; t++) begin
                if (wr_cnt != 1) early = 1;
                line_tick = 1'b1; cyc(1); line_tick = 1'b0;
                cyc(10);
            end
            wait_off(100);
            check(!early && wr_cnt == 2, "R5", wr_cnt, 2);
        end

        // R9/R3: stop leaves address on next word; resume from there
        fill_stop();
        mem[32] = 16'h0311;
        mem[33] = 16'h4020;
        mem[34] = 16'h0322;
        clear_counts();
        start_at(32);
        wait_off(100);
        cyc(2);
        check(wr_cnt == 1 && last_data == 8'h11, "R9", last_data, 8'h11);
        cpu_en_set = 1'b1; cyc(1); cpu_en_set = 1'b0;
        check(chan_en == 1 && mem_req == 0, "R2", chan_en, 1);
        cyc(1);
        check(mem_req == 1 && mem_addr == 16'd34, "R9", mem_addr, 34);
        cyc(1);
        check(mem_req == 1 && mem_addr == 16'd34, "R3", mem_addr, 34);
        wait_off(100);
        cyc(2);
        check(wr_cnt == 2 && last_data == 8'h22, "R9", last_data, 8'h22);

        // R2: clear wins over set in the same cycle
        cpu_en_set = 1'b1; cpu_en_clr = 1'b1; cyc(1);
        cpu_en_set = 1'b0; cpu_en_clr = 1'b0; cyc(1);
        check(chan_en == 0, "R2", chan_en, 0);

        // R10/R2: clear during a long pause, address write while enabled ignored
        fill_stop();
        mem[48] = 16'h1032;
        start_at(48);
        cyc(10);
        addr_wr = 1'b1; addr_in = 16'd5; cyc(1); addr_wr = 1'b0;
        cpu_en_clr = 1'b1; cyc(1); cpu_en_clr = 1'b0;
        cyc(2);
        check(chan_en == 0 && mem_req == 0, "R10", mem_req, 0);
        cpu_en_set = 1'b1; cyc(1); cpu_en_set = 1'b0;
        cyc(1);
        check(mem_req == 1, "R10", mem_req, 1);
        check(mem_addr == 16'd49, "R2", mem_addr, 49);
        wait_off(100);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule